// File: doc/BRIEF.md
# Multi-Mode Address Generation Unit

This block forms the effective memory address of a load or store from a mode code and a set of operands: a base register value, an index register value, a 12-bit signed offset from the instruction, a 2-bit scale code, the current program counter and an absolute address taken from the instruction. For the modes that modify their base register, it also returns the new base value together with a writeback enable. The caller writes that value back into the register file in the same cycle that it issues the memory access at the effective address.

Three of the modes update the base register: post-increment, push and pop. In push and pop the base register acts as a stack pointer on a stack that grows toward lower addresses. Push moves the pointer down first and then accesses the new location. Pop accesses the current location and then moves the pointer up. Post-increment accesses the unmodified base and then advances it by the signed offset. All arithmetic wraps modulo 2^ADDR_W. By default the results are registered, so they appear one cycle after the request.

Top module: `addr_gen_unit`

## Requirements
- R1: Mode code 0 (register indirect): the effective address equals the base input.
- R2: Mode code 1 (base plus offset): the effective address equals the base plus the 12-bit offset, sign-extended from offset bit 11.
- R3: Mode code 2 (scaled index): the effective address equals base + index × S, where scale code 0, 1, 2 and 3 selects S = 1, 2, 4 and 8.
- R4: Mode code 3 (PC-relative): the effective address equals the PC input plus the sign-extended offset.
- R5: Mode code 4 (absolute): the effective address equals the absolute-address input, and base, index and PC have no effect.
- R6: Mode code 5 (post-increment): the effective address equals the unmodified base, and the writeback value equals base + sign-extended offset.
- R7: Mode code 6 (push): the writeback value equals base − 4, and the effective address equals that decremented value.
- R8: Mode code 7 (pop): the effective address equals the unmodified base, and the writeback value equals base + 4.
- R9: The writeback enable is high only for a valid request whose mode code is 5, 6 or 7. It is low for every other mode and whenever no result is valid.
- R10: All address and writeback arithmetic wraps modulo 2^32. For example, a push from 0 yields 0xFFFFFFFC, and a pop from 0xFFFFFFFC writes back 0.
- R11: Each result appears exactly one clock cycle after its request, with out_valid following req_valid. Reset clears out_valid and out_wb_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing mode code (0..7) |
| req_base | input | ADDR_W | Base register / stack pointer value |
| req_index | input | ADDR_W | Index register value |
| req_imm | input | IMM_W | Signed offset or step from the instruction |
| req_scale | input | SCALE_W | Index scale code |
| req_pc | input | ADDR_W | Current program counter |
| req_abs | input | ADDR_W | Absolute address from the instruction |
| out_valid | output | 1 | Result valid |
| out_ea | output | ADDR_W | Effective address |
| out_wb_en | output | 1 | Base register writeback enable |
| out_wb_val | output | ADDR_W | New base register value |

## Verification
The address result and the base writeback fall in the same output cycle for post-increment, push and pop, and the two depend on each other in opposite ways: a push must emit its decremented pointer as both values, while a pop must emit the old pointer as the address and the incremented one as the writeback. The test provokes this with back-to-back push and pop requests that chain the pointer, including pushes and pops across the zero wrap. Each output cycle is judged by comparing the address, the enable and the writeback value against the expected values computed for that request. Requests from non-updating modes are placed between them, and so is an invalid request that carries the push code, to confirm that the enable stays low.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        AM_REG_IND    = 3'd0,
        AM_BASE_OFS   = 3'd1,
        AM_SCALED_IDX = 3'd2,
        AM_PC_REL     = 3'd3,
        AM_ABSOLUTE   = 3'd4,
        AM_POST_INC   = 3'd5,
        AM_PUSH       = 3'd6,
        AM_POP        = 3'd7
    } agu_mode_e;

    localparam int MODE_W = 3;

    // Modes that return a new base register value
    function automatic logic mode_updates(input agu_mode_e m);
        return (m == AM_POST_INC) || (m == AM_PUSH) || (m == AM_POP);
    endfunction

endpackage

// File: rtl/agu_offset_sel.sv
module agu_offset_sel
    import agu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SCALE_W = 2
) (
    input  agu_mode_e             mode,
    input  logic [ADDR_W-1:0]     index_val,
    input  logic [IMM_W-1:0]      imm,
    input  logic [SCALE_W-1:0]    scale,
    output logic [ADDR_W-1:0]     offset,
    output logic [ADDR_W-1:0]     imm_ext
);
    localparam int NUM_SCALES = 1 << SCALE_W;

    logic [ADDR_W-1:0] shifted [NUM_SCALES];

    // One fixed shift per scale code; the code picks among them
    for (genvar s = 0; s < NUM_SCALES; s++) begin : g_scale
        assign shifted[s] = index_val << s;
    end

    assign imm_ext = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};

    always_comb begin
        unique case (mode)
            AM_BASE_OFS,
            AM_PC_REL:     offset = imm_ext;
            AM_SCALED_IDX: offset = shifted[scale];
            default:       offset = '0;
        endcase
    end

endmodule

// File: rtl/agu_base_sel.sv
module agu_base_sel
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  agu_mode_e         mode,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] pc_val,
    input  logic [ADDR_W-1:0] abs_val,
    output logic [ADDR_W-1:0] operand
);
    always_comb begin
        unique case (mode)
            AM_PC_REL:   operand = pc_val;
            AM_ABSOLUTE: operand = abs_val;
            default:     operand = base_val;
        endcase
    end

endmodule

// File: rtl/agu_update.sv
module agu_update
    import agu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int STACK_STEP = 4
) (
    input  logic              valid,
    input  agu_mode_e         mode,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] imm_ext,
    output logic              wb_en,
    output logic [ADDR_W-1:0] new_base
);
    localparam logic [ADDR_W-1:0] STEP_UP   = ADDR_W'(STACK_STEP);
    localparam logic [ADDR_W-1:0] STEP_DOWN = ADDR_W'(0) - STEP_UP;

    logic [ADDR_W-1:0] delta;

    always_comb begin
        unique case (mode)
            AM_PUSH:     delta = STEP_DOWN;
            AM_POP:      delta = STEP_UP;
            AM_POST_INC: delta = imm_ext;
            default:     delta = '0;
        endcase
    end

    assign new_base = base_val + delta;
    assign wb_en    = valid && mode_updates(mode);

endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
    parameter int W         = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         d_valid,
    input  logic [W-1:0] d_data,
    output logic         q_valid,
    output logic [W-1:0] q_data
);
    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_valid <= 1'b0;
                q_data  <= '0;
            end else begin
                q_valid <= d_valid;
                q_data  <= d_data;
            end
        end
    end else begin : g_pass
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign q_valid    = d_valid;
        assign q_data     = d_data;
    end

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
    import agu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 12,
    parameter int SCALE_W    = 2,
    parameter int STACK_STEP = 4,
    parameter bit REG_OUT    = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [MODE_W-1:0]  req_mode,
    input  logic [ADDR_W-1:0]  req_base,
    input  logic [ADDR_W-1:0]  req_index,
    input  logic [IMM_W-1:0]   req_imm,
    input  logic [SCALE_W-1:0] req_scale,
    input  logic [ADDR_W-1:0]  req_pc,
    input  logic [ADDR_W-1:0]  req_abs,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_ea,
    output logic               out_wb_en,
    output logic [ADDR_W-1:0]  out_wb_val
);
    localparam int PACK_W = 2*ADDR_W + 1;

    agu_mode_e         mode;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] operand;
    logic [ADDR_W-1:0] sum_ea;
    logic [ADDR_W-1:0] new_base;
    logic              wb_en;
    logic [ADDR_W-1:0] ea;
    logic [PACK_W-1:0] pack_d;
    logic [PACK_W-1:0] pack_q;

    assign mode = agu_mode_e'(req_mode);

    agu_offset_sel #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W),
        .SCALE_W(SCALE_W)
    ) u_offset (
        .mode     (mode),
        .index_val(req_index),
        .imm      (req_imm),
        .scale    (req_scale),
        .offset   (offset),
        .imm_ext  (imm_ext)
    );

    agu_base_sel #(
        .ADDR_W(ADDR_W)
    ) u_base (
        .mode    (mode),
        .base_val(req_base),
        .pc_val  (req_pc),
        .abs_val (req_abs),
        .operand (operand)
    );

    agu_update #(
        .ADDR_W    (ADDR_W),
        .STACK_STEP(STACK_STEP)
    ) u_update (
        .valid   (req_valid),
        .mode    (mode),
        .base_val(req_base),
        .imm_ext (imm_ext),
        .wb_en   (wb_en),
        .new_base(new_base)
    );

    assign sum_ea = operand + offset;

    // Push accesses the already-decremented pointer
    always_comb begin
        unique case (mode)
            AM_PUSH: ea = new_base;
            default: ea = sum_ea;
        endcase
    end

    assign pack_d = {wb_en, ea, new_base};

    agu_out_stage #(
        .W         (PACK_W),
        .REGISTERED(REG_OUT)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_valid(req_valid),
        .d_data (pack_d),
        .q_valid(out_valid),
        .q_data (pack_q)
    );

    assign out_wb_en  = pack_q[PACK_W-1];
    assign out_ea     = pack_q[2*ADDR_W-1:ADDR_W];
    assign out_wb_val = pack_q[ADDR_W-1:0];

endmodule

// File: rtl/agu_checker.sv
module agu_checker
    import agu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 12,
    parameter int SCALE_W    = 2,
    parameter int STACK_STEP = 4,
    parameter bit REG_OUT    = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [MODE_W-1:0]  req_mode,
    input logic [ADDR_W-1:0]  req_base,
    input logic [ADDR_W-1:0]  req_index,
    input logic [IMM_W-1:0]   req_imm,
    input logic [SCALE_W-1:0] req_scale,
    input logic [ADDR_W-1:0]  req_pc,
    input logic [ADDR_W-1:0]  req_abs,
    input logic               out_valid,
    input logic [ADDR_W-1:0]  out_ea,
    input logic               out_wb_en,
    input logic [ADDR_W-1:0]  out_wb_val
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STACK_STEP);

    logic               d_valid;
    logic [MODE_W-1:0]  d_mode;
    logic [ADDR_W-1:0]  d_base;
    logic [ADDR_W-1:0]  d_index;
    logic [IMM_W-1:0]   d_imm;
    logic [SCALE_W-1:0] d_scale;
    logic [ADDR_W-1:0]  d_abs;
    logic [ADDR_W-1:0]  d_pc;

    if (REG_OUT) begin : g_delay
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_valid <= 1'b0;
                d_mode  <= '0;
                d_base  <= '0;
                d_index <= '0;
                d_imm   <= '0;
                d_scale <= '0;
                d_abs   <= '0;
                d_pc    <= '0;
            end else begin
                d_valid <= req_valid;
                d_mode  <= req_mode;
                d_base  <= req_base;
                d_index <= req_index;
                d_imm   <= req_imm;
                d_scale <= req_scale;
                d_abs   <= req_abs;
                d_pc    <= req_pc;
            end
        end
    end else begin : g_direct
        assign d_valid = req_valid;
        assign d_mode  = req_mode;
        assign d_base  = req_base;
        assign d_index = req_index;
        assign d_imm   = req_imm;
        assign d_scale = req_scale;
        assign d_abs   = req_abs;
        assign d_pc    = req_pc;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == d_valid); // R11

    AST_REG_IND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_mode == AM_REG_IND) |-> out_ea == d_base); // R1

    AST_SCALED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_mode == AM_SCALED_IDX) |-> out_ea == d_base + (d_index << d_scale)); // R3

    AST_PC_REL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_mode == AM_PC_REL)
            |-> out_ea == d_pc + {{(ADDR_W-IMM_W){d_imm[IMM_W-1]}}, d_imm}); // R4

    AST_ABSOLUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_mode == AM_ABSOLUTE) |-> out_ea == d_abs); // R5

    AST_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_mode == AM_POST_INC) |-> out_ea == d_base); // R6

    AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_mode == AM_PUSH)
            |-> (out_ea == out_wb_val) && (out_wb_val == d_base - STEP)); // R7

    AST_POP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_mode == AM_POP)
            |-> (out_ea == d_base) && (out_wb_val == d_base + STEP)); // R8

    AST_WB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        out_wb_en |-> out_valid && (d_mode == AM_POST_INC || d_mode == AM_PUSH
                                    || d_mode == AM_POP)); // R9

    AST_WB_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && d_mode == AM_POP) |-> out_wb_en); // R9

endmodule

bind addr_gen_unit agu_checker #(
    .ADDR_W    (ADDR_W),
    .IMM_W     (IMM_W),
    .SCALE_W   (SCALE_W),
    .STACK_STEP(STACK_STEP),
    .REG_OUT   (REG_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_base  (req_base),
    .req_index (req_index),
    .req_imm   (req_imm),
    .req_scale (req_scale),
    .req_pc    (req_pc),
    .req_abs   (req_abs),
    .out_valid (out_valid),
    .out_ea    (out_ea),
    .out_wb_en (out_wb_en),
    .out_wb_val(out_wb_val)
);

// File: tb/addr_gen_unit_tb.sv
module addr_gen_unit_tb;

    typedef struct {
        logic [31:0] ea;
        logic        wb_en;
        logic [31:0] wb_val;
        string       tag;
    } exp_t;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_mode;
    logic [31:0] req_base;
    logic [31:0] req_index;
    logic [11:0] req_imm;
    logic [1:0]  req_scale;
    logic [31:0] req_pc;
    logic [31:0] req_abs;
    logic        out_valid;
    logic [31:0] out_ea;
    logic        out_wb_en;
    logic [31:0] out_wb_val;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   mon_on   = 1'b0;
    bit   done     = 1'b0;

    addr_gen_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_mode  (req_mode),
        .req_base  (req_base),
        .req_index (req_index),
        .req_imm   (req_imm),
        .req_scale (req_scale),
        .req_pc    (req_pc),
        .req_abs   (req_abs),
        .out_valid (out_valid),
        .out_ea    (out_ea),
        .out_wb_en (out_wb_en),
        .out_wb_val(out_wb_val)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [11:0] v);
        return {{20{v[11]}}, v};
    endfunction

    // Driver: applies one request and queues its expected result
    task automatic issue(input logic [2:0] m, input logic [31:0] base,
                         input logic [31:0] idx, input logic [11:0] imm,
                         input logic [1:0] sc, input logic [31:0] pc,
                         input logic [31:0] abs_a, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_base = base; req_index = idx;
        req_imm = imm; req_scale = sc; req_pc = pc; req_abs = abs_a;
        e.tag = tag; e.wb_en = 1'b0; e.wb_val = 32'h0;
        case (m)
            3'd0: e.ea = base;
            3'd1: e.ea = base + sx(imm);
            3'd2: e.ea = base + idx * (32'd1 << sc);
            3'd3: e.ea = pc + sx(imm);
            3'd4: e.ea = abs_a;
            3'd5: begin e.ea = base; e.wb_en = 1'b1; e.wb_val = base + sx(imm); end
            3'd6: begin e.wb_val = base - 32'd4; e.ea = e.wb_val; e.wb_en = 1'b1; end
            default: begin e.ea = base; e.wb_en = 1'b1; e.wb_val = base + 32'd4; end
        endcase
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: pops and compares every valid result
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R11", "unexpected out_valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, "ea", out_ea, e.ea);
                    check("R9", {e.tag, " wb_en"}, {31'd0, out_wb_en}, {31'd0, e.wb_en});
                    if (e.wb_en) check(e.tag, "wb_val", out_wb_val, e.wb_val);
                end
            end else begin
                check("R9", "wb_en while idle", {31'd0, out_wb_en}, 32'd0);
            end
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b1; req_mode = 3'd6; req_base = 32'h100;
        req_index = '0; req_imm = '0; req_scale = '0; req_pc = '0; req_abs = '0;
        repeat (3) @(negedge clk);
        check("R11", "out_valid in reset", {31'd0, out_valid}, 32'd0);
        check("R11", "wb_en in reset", {31'd0, out_wb_en}, 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(2);

        issue(3'd0, 32'h1000_0040, 32'h5, 12'h123, 2'd1, 32'h9, 32'h7, "R1");
        issue(3'd1, 32'h0000_2000, 32'h0, 12'h7FF, 2'd0, 32'h0, 32'h0, "R2");
        issue(3'd1, 32'h0000_0100, 32'h0, 12'h800, 2'd0, 32'h0, 32'h0, "R2");
        for (int s = 0; s < 4; s++)
            issue(3'd2, 32'h0001_0000, 32'h0000_0013, 12'h0, 2'(s), 32'h0, 32'h0, "R3");
        issue(3'd2, 32'hFFFF_FFF0, 32'h4, 12'h0, 2'd2, 32'h0, 32'h0, "R10");
        issue(3'd3, 32'hDEAD_0000, 32'h0, 12'hFFC, 2'd0, 32'h8000_0000, 32'h0, "R4");
        issue(3'd3, 32'h0, 32'h0, 12'h010, 2'd0, 32'h0000_4000, 32'h0, "R4");
        issue(3'd4, 32'h1111_1111, 32'h2222, 12'h333, 2'd3, 32'h4444, 32'h0000_4000, "R5");
        issue(3'd5, 32'h0000_3000, 32'h0, 12'h004, 2'd0, 32'h0, 32'h0, "R6");
        issue(3'd5, 32'h0000_3000, 32'h0, 12'hFF8, 2'd0, 32'h0, 32'h0, "R6");
        // Push/pop chain: writeback and access in the same result cycle
        issue(3'd6, 32'h2000_0000, 32'h0, 12'h0, 2'd0, 32'h0, 32'h0, "R7");
        issue(3'd6, 32'h1FFF_FFFC, 32'h0, 12'h0, 2'd0, 32'h0, 32'h0, "R7");
        issue(3'd0, 32'h1FFF_FFF8, 32'h0, 12'h0, 2'd0, 32'h0, 32'h0, "R9");
        issue(3'd7, 32'h1FFF_FFF8, 32'h0, 12'h0, 2'd0, 32'h0, 32'h0, "R8");
        issue(3'd7, 32'h1FFF_FFFC, 32'h0, 12'h0, 2'd0, 32'h0, 32'h0, "R8");
        issue(3'd6, 32'h0000_0000, 32'h0, 12'h0, 2'd0, 32'h0, 32'h0, "R10");
        issue(3'd7, 32'hFFFF_FFFC, 32'h0, 12'h0, 2'd0, 32'h0, 32'h0, "R10");
        // Invalid request carrying the push code must not enable writeback
        @(negedge clk);
        req_valid = 1'b0; req_mode = 3'd6; req_base = 32'h500;
        issue(3'd7, 32'h0000_0800, 32'h0, 12'h0, 2'd0, 32'h0, 32'h0, "R8");
        idle(4);
        check("R11", "results outstanding", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule